// File: doc/BRIEF.md
# Bridge I/O Forwarding Decoder

This block decides, for each processor-initiated cycle, whether a virtual PCI-to-PCI bridge forwards it to the secondary graphics/PCI bus or leaves it on the primary hub interface. It holds three small configuration registers, written and read over a simple byte-wide config port:

- a bridge control byte;
- an I/O base nibble;
- an I/O limit nibble.

It combines these registers with the address and type of each request. The decode covers three things: an inclusive I/O window, optional exclusion of ISA alias addresses inside that window, and routing of the legacy VGA memory and I/O ranges. The routing decision is registered and appears one clock after the request.

The block also handles two secondary-side events. A master abort is completed locally without any error: a read returns all ones and a write is discarded. A parity error on the secondary bus is forwarded as a report only when the control register's parity-response bit and the primary SERR enable are both set.

Top module: `bridge_io_decoder`

## Requirements
- R1: After reset, the control register reads 00h, the base register reads F0h and the limit register reads 00h. With these values the I/O window is disabled.
- R2: Config select values are: 0 for control, 1 for base, 2 for limit. Select 3 reads 00h and ignores writes. In the control register only bit 3 (VGA enable), bit 2 (ISA enable) and bit 0 (parity response) are writable. All other control bits read 0 whatever is written.
- R3: The base and limit registers hold a nibble in bits [7:4] and read 0 in bits [3:0]. An I/O address is inside the window when address bits [15:12] are at least base and at most limit, both ends included. When base is greater than limit, no address is inside the window.
- R4: With ISA enable at 0, every I/O address inside the window routes to the secondary bus (route_secondary=1).
- R5: With ISA enable at 1, an in-window I/O address whose bits [9:8] are not both 0 routes to the hub (route_secondary=0). An in-window address with bits [9:8]=00 still routes to the secondary bus.
- R6: An I/O address outside the window routes to the hub, whatever the ISA enable setting.
- R7: With VGA enable at 1, certain ranges route to the secondary bus regardless of the window and of ISA enable. These are memory addresses A0000h–BFFFFh and I/O addresses whose low 10 bits fall in 3B0h–3BBh or 3C0h–3DFh. With VGA enable at 0, these ranges follow the normal rules, and memory cycles route to the hub.
- R8: route_valid pulses exactly one cycle after each accepted request and stays low otherwise. route_secondary is 0 whenever route_valid is 0.
- R9: A master abort pulse yields cpl_valid one cycle later with cpl_is_read echoing the cycle type. cpl_data is all ones for a read and zero for a write.
- R10: serr_report is 1 one cycle after sec_perr only when control bit 0 and serr_en were both 1 in that cycle. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Register select (0 control, 1 base, 2 limit) |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data for the selected register |
| req_valid | input | 1 | Processor cycle present |
| req_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_addr | input | ADDR_W | Cycle address |
| route_valid | output | 1 | Routing decision valid |
| route_secondary | output | 1 | 1 = forward to secondary bus, 0 = hub |
| mabort_valid | input | 1 | Master abort seen on secondary bus |
| mabort_is_read | input | 1 | Aborted cycle was a read |
| cpl_valid | output | 1 | Local completion of an aborted cycle |
| cpl_is_read | output | 1 | Completion is for a read |
| cpl_data | output | DATA_W | Completion read data |
| sec_perr | input | 1 | Parity error detected on secondary bus |
| serr_en | input | 1 | Primary SERR enable |
| serr_report | output | 1 | Parity error report toward primary |

## Verification
Wrong control or window state does not raise any error flag. It shows only as a routing decision that points at the wrong bus, one cycle after the request that exposes it. It is also visible right away in the config readback. An error in the ISA hole or the VGA alias shows only for addresses with particular values in bits [9:8] or bits [9:0]. For that reason, the window edges, hole and non-hole offsets, and aliased VGA addresses are each probed directly. Completion and parity-report faults appear on the cycle after the triggering pulse.

// File: rtl/bridge_io_decoder.sv
module bridge_io_decoder #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              route_valid,
  output logic              route_secondary,
  input  logic              mabort_valid,
  input  logic              mabort_is_read,
  output logic              cpl_valid,
  output logic              cpl_is_read,
  output logic [DATA_W-1:0] cpl_data,
  input  logic              sec_perr,
  input  logic              serr_en,
  output logic              serr_report
);
  localparam logic [7:0] CTRL_RW = 8'h0D;
  localparam int VGA_EN = 3;
  localparam int ISA_EN = 2;
  localparam int PAR_EN = 0;

  logic [7:0] ctrl_q;
  logic [3:0] base_q, limit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= 8'h00;
      base_q  <= 4'hF;
      limit_q <= 4'h0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: ctrl_q  <= cfg_wdata & CTRL_RW;
        2'd1: base_q  <= cfg_wdata[7:4];
        2'd2: limit_q <= cfg_wdata[7:4];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = ctrl_q;
      2'd1:    cfg_rdata = {base_q, 4'h0};
      2'd2:    cfg_rdata = {limit_q, 4'h0};
      default: cfg_rdata = 8'h00;
    endcase
  end

  logic [3:0] io_blk;
  logic [9:0] io_low;
  logic       in_win, isa_hole, vga_io, vga_mem, to_sec;

  assign io_blk   = req_addr[15:12];
  assign io_low   = req_addr[9:0];
  assign in_win   = (base_q <= limit_q) && (io_blk >= base_q) && (io_blk <= limit_q);
  assign isa_hole = ctrl_q[ISA_EN] && (io_low[9:8] != 2'b00);
  assign vga_io   = ((io_low >= 10'h3B0) && (io_low <= 10'h3BB)) ||
                    ((io_low >= 10'h3C0) && (io_low <= 10'h3DF));
  assign vga_mem  = (req_addr >= ADDR_W'('hA0000)) && (req_addr <= ADDR_W'('hBFFFF));

  always_comb begin
    if (req_is_io)
      to_sec = (ctrl_q[VGA_EN] && vga_io) || (in_win && !isa_hole);
    else
      to_sec = ctrl_q[VGA_EN] && vga_mem;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_valid     <= 1'b0;
      route_secondary <= 1'b0;
      cpl_valid       <= 1'b0;
      cpl_is_read     <= 1'b0;
      cpl_data        <= '0;
      serr_report     <= 1'b0;
    end else begin
      route_valid     <= req_valid;
      route_secondary <= req_valid && to_sec;
      cpl_valid       <= mabort_valid;
      cpl_is_read     <= mabort_valid && mabort_is_read;
      cpl_data        <= (mabort_valid && mabort_is_read) ? '1 : '0;
      serr_report     <= sec_perr && ctrl_q[PAR_EN] && serr_en;
    end
  end
endmodule

module bridge_io_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_sel,
  input logic [7:0]        cfg_rdata,
  input logic [7:0]        ctrl_q,
  input logic              req_valid,
  input logic              req_is_io,
  input logic [ADDR_W-1:0] req_addr,
  input logic              route_valid,
  input logic              route_secondary,
  input logic              mabort_valid,
  input logic              mabort_is_read,
  input logic              cpl_valid,
  input logic              cpl_is_read,
  input logic [DATA_W-1:0] cpl_data,
  input logic              sec_perr,
  input logic              serr_en,
  input logic              serr_report
);
  AST_CTRL_RO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'd0) |-> ((cfg_rdata & 8'hF2) == 8'h00)); // R2
  AST_ROUTE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    route_secondary |-> route_valid); // R8
  AST_ROUTE_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> route_valid); // R8
  AST_ISA_HOLE_HUB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io && !ctrl_q[3] && ctrl_q[2] && (req_addr[9:8] != 2'b00))
      |=> !route_secondary); // R5
  AST_ABORT_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (mabort_valid && mabort_is_read) |=> (cpl_valid && cpl_is_read && (&cpl_data))); // R9
  AST_ABORT_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mabort_valid && !mabort_is_read) |=> (cpl_valid && !cpl_is_read && (cpl_data == '0))); // R9
  AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_perr && ctrl_q[0] && serr_en) |=> serr_report); // R10
  AST_PERR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_perr && ctrl_q[0] && serr_en) |=> !serr_report); // R10
endmodule

bind bridge_io_decoder bridge_io_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata), .ctrl_q(ctrl_q),
  .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
  .route_valid(route_valid), .route_secondary(route_secondary),
  .mabort_valid(mabort_valid), .mabort_is_read(mabort_is_read),
  .cpl_valid(cpl_valid), .cpl_is_read(cpl_is_read), .cpl_data(cpl_data),
  .sec_perr(sec_perr), .serr_en(serr_en), .serr_report(serr_report)
);

// File: tb/bridge_io_decoder_test.sv
module bridge_io_decoder_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_is_io = 1'b0;
  logic [31:0] req_addr = 32'h0;
  logic        route_valid, route_secondary;
  logic        mabort_valid = 1'b0, mabort_is_read = 1'b0;
  logic        cpl_valid, cpl_is_read;
  logic [31:0] cpl_data;
  logic        sec_perr = 1'b0, serr_en = 1'b0;
  logic        serr_report;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  bridge_io_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
    .route_valid(route_valid), .route_secondary(route_secondary),
    .mabort_valid(mabort_valid), .mabort_is_read(mabort_is_read),
    .cpl_valid(cpl_valid), .cpl_is_read(cpl_is_read), .cpl_data(cpl_data),
    .sec_perr(sec_perr), .serr_en(serr_en), .serr_report(serr_report)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input string req, input logic [1:0] sel, input logic [7:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #1 check(req, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic route(input string req, input logic io, input logic [31:0] a, input logic exp);
    @(negedge clk);
    req_valid = 1'b1; req_is_io = io; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {31'h0, route_valid}, 32'h1);
    check(req, {31'h0, route_secondary}, {31'h0, exp});
  endtask

  task automatic test_reset();
    cfg_read("R1 ctrl", 2'd0, 8'h00);
    cfg_read("R1 base", 2'd1, 8'hF0);
    cfg_read("R1 limit", 2'd2, 8'h00);
    route("R1 window off", 1'b1, 32'h0000_0100, 1'b0);
  endtask

  task automatic test_regs();
    cfg_write(2'd0, 8'hFF);
    cfg_read("R2 ctrl mask", 2'd0, 8'h0D);
    cfg_write(2'd0, 8'h00);
    cfg_read("R2 ctrl clear", 2'd0, 8'h00);
    cfg_write(2'd3, 8'hFF);
    cfg_read("R2 sel3", 2'd3, 8'h00);
    cfg_read("R2 sel3 no effect", 2'd0, 8'h00);
    cfg_write(2'd1, 8'h2F);
    cfg_write(2'd2, 8'h3A);
    cfg_read("R3 base nibble", 2'd1, 8'h20);
    cfg_read("R3 limit nibble", 2'd2, 8'h30);
  endtask

  task automatic test_window();
    route("R3 low edge", 1'b1, 32'h0000_2000, 1'b1);
    route("R3 high edge", 1'b1, 32'h0000_3FFF, 1'b1);
    route("R3 below", 1'b1, 32'h0000_1FFF, 1'b0);
    route("R3 above", 1'b1, 32'h0000_4000, 1'b0);
    route("R4 isa off", 1'b1, 32'h0000_2300, 1'b1);
    route("R4 isa off 100", 1'b1, 32'h0000_3100, 1'b1);
  endtask

  task automatic test_isa();
    cfg_write(2'd0, 8'h04);
    route("R5 hole 300", 1'b1, 32'h0000_2300, 1'b0);
    route("R5 hole 100", 1'b1, 32'h0000_2100, 1'b0);
    route("R5 hole 200", 1'b1, 32'h0000_3E00, 1'b0);
    route("R5 keep 000", 1'b1, 32'h0000_2000, 1'b1);
    route("R5 keep 0FF", 1'b1, 32'h0000_24FF, 1'b1);
    route("R6 outside", 1'b1, 32'h0000_5300, 1'b0);
    route("R6 outside 000", 1'b1, 32'h0000_5000, 1'b0);
  endtask

  task automatic test_vga();
    cfg_write(2'd0, 8'h0C);
    route("R7 io alias", 1'b1, 32'h0000_73C0, 1'b1);
    route("R7 io 3B0", 1'b1, 32'h0000_03B0, 1'b1);
    route("R7 io 3BB", 1'b1, 32'h0000_03BB, 1'b1);
    route("R7 io 3BC", 1'b1, 32'h0000_03BC, 1'b0);
    route("R7 io 3DF", 1'b1, 32'h0000_03DF, 1'b1);
    route("R7 io 3E0", 1'b1, 32'h0000_03E0, 1'b0);
    route("R7 in hole", 1'b1, 32'h0000_23C5, 1'b1);
    route("R7 mem A0000", 1'b0, 32'h000A_0000, 1'b1);
    route("R7 mem BFFFF", 1'b0, 32'h000B_FFFF, 1'b1);
    route("R7 mem C0000", 1'b0, 32'h000C_0000, 1'b0);
    route("R7 mem 9FFFF", 1'b0, 32'h0009_FFFF, 1'b0);
    cfg_write(2'd0, 8'h04);
    route("R7 off mem", 1'b0, 32'h000A_0000, 1'b0);
    route("R7 off io", 1'b1, 32'h0000_03C0, 1'b0);
  endtask

  task automatic test_inverted();
    cfg_write(2'd0, 8'h00);
    cfg_write(2'd1, 8'h50);
    cfg_write(2'd2, 8'h40);
    route("R3 inverted 5", 1'b1, 32'h0000_5000, 1'b0);
    route("R3 inverted 4", 1'b1, 32'h0000_4000, 1'b0);
  endtask

  task automatic test_idle();
    @(negedge clk);
    @(negedge clk);
    check("R8 idle valid", {31'h0, route_valid}, 32'h0);
    check("R8 idle sec", {31'h0, route_secondary}, 32'h0);
  endtask

  task automatic test_abort();
    @(negedge clk);
    mabort_valid = 1'b1; mabort_is_read = 1'b1;
    @(negedge clk);
    mabort_valid = 1'b0;
    check("R9 rd valid", {31'h0, cpl_valid}, 32'h1);
    check("R9 rd type", {31'h0, cpl_is_read}, 32'h1);
    check("R9 rd ones", cpl_data, 32'hFFFF_FFFF);
    mabort_valid = 1'b1; mabort_is_read = 1'b0;
    @(negedge clk);
    mabort_valid = 1'b0;
    check("R9 wr valid", {31'h0, cpl_valid}, 32'h1);
    check("R9 wr type", {31'h0, cpl_is_read}, 32'h0);
    check("R9 wr data", cpl_data, 32'h0);
    @(negedge clk);
    check("R9 one pulse", {31'h0, cpl_valid}, 32'h0);
  endtask

  task automatic perr_case(input string req, input logic par, input logic se, input logic exp);
    cfg_write(2'd0, {7'h0, par});
    @(negedge clk);
    sec_perr = 1'b1; serr_en = se;
    @(negedge clk);
    sec_perr = 1'b0;
    check(req, {31'h0, serr_report}, {31'h0, exp});
  endtask

  task automatic test_parity();
    perr_case("R10 par off", 1'b0, 1'b1, 1'b0);
    perr_case("R10 serr off", 1'b1, 1'b0, 1'b0);
    perr_case("R10 both on", 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R10 no perr", {31'h0, serr_report}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_regs();
    test_window();
    test_isa();
    test_vga();
    test_inverted();
    test_idle();
    test_abort();
    test_parity();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule